// File: doc/BRIEF.md
# Per-CPU Masked Interrupt Aggregator

This block is a first-level interrupt collector. It takes 32×N level-sensitive interrupt sources, where N is a parameter of 2 or 4 words. It folds them into one interrupt line for each of two processors. Each source level passes through a two-stage synchronizer and becomes a status bit. Each processor owns a private set of N full-word enable registers. A processor's line is raised while any synchronized source that the processor has enabled is high. Nothing is latched, so a line drops as soon as its sources fall or are masked.

Software reaches both register banks over a plain single-cycle read/write bus with byte addresses. Within a bank, the enable words come first and the status words follow. The word order is reversed, so the lowest address of each group covers the highest-numbered sources. To change one bit of an enable word, software writes back the whole word. There are no set or clear aliases. Both banks show the same status bits; only the enable words differ between processors.

Top module: `irqagg_top`

## Requirements
- R1: After reset, every enable word of both processors reads 0, both `cpu_irq` bits are 0 and `bus_rdata` is 0.
- R2: The address decode uses `bus_addr` with bits [1:0] ignored, and banks are 8×N bytes long:
  - Processor c's bank starts at byte c×8N.
  - Within a bank, the enable slots are at offsets 0 to 4N−4 and the status slots are at offsets 4N to 8N−4.
  - Slot k of either group (k counted from 0 in steps of 4 bytes) refers to word N−1−k.
  - Word w covers sources 32w to 32w+31, and bit b of that word is source 32w+b.
- R3: A write to an enable slot stores all 32 bits of `bus_wdata`, and a later read of that slot returns them. A write to one processor's bank leaves the other processor's enable words unchanged.
- R4: A status slot reads the synchronized source levels. These levels trail `src_level` by two clock edges, and both banks return the same status value for the same word.
- R5: Read data is registered. If `bus_rd_en` is high at a clock edge, `bus_rdata` shows the addressed value after that edge. If `bus_rd_en` is low at an edge, `bus_rdata` is 0 after it.
- R6: `cpu_irq[c]` is a register that takes the OR of (status AND processor c's enables) at each edge. An enable write at edge E is seen in `cpu_irq` after edge E+1. A source change is seen after the third edge.
- R7: A write to a status slot changes no enable word and no status bit.
- R8: Byte addresses at or above 16N are unmapped. A write there is ignored, and a read there returns 0.
- R9: The block latches nothing. A source that is high for one cycle raises an enabled line for exactly one cycle, three edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | 32×N_WORDS | Level-sensitive interrupt sources |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_rd_en | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | 2 | Interrupt line for each processor |

## Verification
A source change reaches the status read-back after two edges and a processor line after three. An enable write changes the line one edge after it lands. Read data appears one edge after the strobe. The bench's reference model steps by one clock edge with these same depths and is compared with both outputs at every falling edge. The directed checks drive inputs just after a falling edge and sample after the counted number of rising edges. Around mask writes they sample twice, once before the line may move and once after.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int unsigned SRC_PER_WORD = 32;
    localparam int unsigned CPU_COUNT    = 2;
    localparam int unsigned MAX_WORDS    = 4;

    typedef enum logic [1:0] {
        SLOT_NONE   = 2'd0,
        SLOT_ENABLE = 2'd1,
        SLOT_STATUS = 2'd2
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e kind;
        logic       cpu;
        logic [1:0] word;
    } slot_t;

    // Byte address -> register slot. Word order inside each group is reversed.
    function automatic slot_t map_address(input logic [31:0] byte_addr,
                                          input int unsigned n_words);
        slot_t       r;
        int unsigned widx;
        int unsigned per_bank;
        int unsigned inner;
        r.kind   = SLOT_NONE;
        r.cpu    = 1'b0;
        r.word   = 2'd0;
        widx     = byte_addr >> 2;
        per_bank = 2 * n_words;
        inner    = 0;
        if (widx < CPU_COUNT * per_bank) begin
            r.cpu = 1'(widx / per_bank);
            inner = widx % per_bank;
            if (inner < n_words) begin
                r.kind = SLOT_ENABLE;
                r.word = 2'(n_words - 1 - inner);
            end else begin
                r.kind = SLOT_STATUS;
                r.word = 2'(2 * n_words - 1 - inner);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int unsigned WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/irqagg_cpu_bank.sv
module irqagg_cpu_bank
    import irqagg_pkg::*;
#(
    parameter int unsigned N_WORDS = 2,
    parameter int unsigned WIDX_W  = 1
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   wr_en,
    input  logic [WIDX_W-1:0]                      wr_word,
    input  logic [SRC_PER_WORD-1:0]                wr_data,
    input  logic [N_WORDS-1:0][SRC_PER_WORD-1:0]   status,
    output logic [N_WORDS-1:0][SRC_PER_WORD-1:0]   en_words,
    output logic                                   irq_o
);

    logic pend_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_words <= '0;
        end else begin
            for (int w = 0; w < N_WORDS; w++) begin
                if (wr_en && (wr_word == WIDX_W'(w))) begin
                    en_words[w] <= wr_data;
                end
            end
        end
    end

    assign pend_any = |(status & en_words);

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= pend_any;
    end

    // R3: a write lands in the addressed word on the next cycle
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (en_words[$past(wr_word)] == $past(wr_data)));

    // R6: a fully masked bank keeps its line low one edge later
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (en_words == '0) |=> !irq_o);

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int unsigned N_WORDS = 2,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [SRC_PER_WORD*N_WORDS-1:0]  src_level,
    input  logic                             bus_wr_en,
    input  logic                             bus_rd_en,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [SRC_PER_WORD-1:0]          bus_wdata,
    output logic [SRC_PER_WORD-1:0]          bus_rdata,
    output logic [CPU_COUNT-1:0]             cpu_irq
);

    localparam int unsigned N_SRC     = SRC_PER_WORD * N_WORDS;
    localparam int unsigned WIDX_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam int unsigned MAP_BYTES = CPU_COUNT * N_WORDS * 8;

    logic [N_WORDS-1:0][SRC_PER_WORD-1:0]                 status_words;
    logic [CPU_COUNT-1:0][N_WORDS-1:0][SRC_PER_WORD-1:0]  en_all;
    slot_t                                                slot;
    logic [WIDX_W-1:0]                                    slot_word;

    assign slot      = map_address(32'(bus_addr), N_WORDS);
    assign slot_word = slot.word[WIDX_W-1:0];

    irqagg_sync #(.WIDTH(N_SRC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (src_level),
        .q   (status_words)
    );

    for (genvar c = 0; c < CPU_COUNT; c++) begin : g_bank
        logic bank_wr;
        assign bank_wr = bus_wr_en && (slot.kind == SLOT_ENABLE) && (slot.cpu == 1'(c));

        irqagg_cpu_bank #(.N_WORDS(N_WORDS), .WIDX_W(WIDX_W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (bank_wr),
            .wr_word  (slot_word),
            .wr_data  (bus_wdata),
            .status   (status_words),
            .en_words (en_all[c]),
            .irq_o    (cpu_irq[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd_en) begin
            unique case (slot.kind)
                SLOT_ENABLE: bus_rdata <= en_all[slot.cpu][slot_word];
                SLOT_STATUS: bus_rdata <= status_words[slot_word];
                default:     bus_rdata <= '0;
            endcase
        end else begin
            bus_rdata <= '0;
        end
    end

    // R5: no strobe, no data
    a_r5_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_en |=> (bus_rdata == '0));

    // R8: reads past the mapped window return zero
    a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && (int'(bus_addr) >= MAP_BYTES)) |=> (bus_rdata == '0));

    // R7 / R8: writes that miss every enable slot leave all enables alone
    a_r7_ignored_write_keeps_enables: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && (slot.kind != SLOT_ENABLE)) |=> $stable(en_all));

endmodule

// File: tb/irqagg_top_tb.sv
module irqagg_top_tb;

    localparam int NW  = 2;
    localparam int NS  = 32 * NW;
    localparam int AW  = 8;
    localparam int WATCHDOG_CYCLES = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [1:0]    irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    irqagg_top #(.N_WORDS(NW), .ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .src_level (src),
        .bus_wr_en (wr_en),
        .bus_rd_en (rd_en),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .cpu_irq   (irq)
    );

    always #5 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [NS-1:0] m_s1, m_s2;
    logic [31:0]   m_en [2][NW];
    logic [1:0]    m_irq;
    logic [31:0]   m_rd;
    string         m_rtag = "R1";

    // kind: 0 none, 1 enable, 2 status
    task automatic lookup(input int byte_a, output int kind, output int cpu, output int word);
        int off;
        kind = 0; cpu = 0; word = 0;
        if (byte_a < 16 * NW) begin
            cpu = byte_a / (8 * NW);
            off = byte_a % (8 * NW);
            if (off < 4 * NW) begin kind = 1; word = NW - 1 - off / 4; end
            else begin kind = 2; word = NW - 1 - (off - 4 * NW) / 4; end
        end
    endtask

    always @(posedge clk) begin
        int kind, cpu, word;
        logic [1:0] nirq;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_irq = '0; m_rd = '0; m_rtag = "R1";
            for (int c = 0; c < 2; c++) for (int w = 0; w < NW; w++) m_en[c][w] = '0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                nirq[c] = 1'b0;
                for (int w = 0; w < NW; w++)
                    if ((m_en[c][w] & m_s2[32*w +: 32]) != 0) nirq[c] = 1'b1;
            end
            m_rd = '0; m_rtag = "R5";
            if (rd_en) begin
                lookup(int'(addr) & ~3, kind, cpu, word);
                if (kind == 1) begin m_rd = m_en[cpu][word]; m_rtag = "R3"; end
                else if (kind == 2) begin m_rd = m_s2[32*word +: 32]; m_rtag = "R4"; end
                else m_rtag = "R8";
            end
            if (wr_en) begin
                lookup(int'(addr) & ~3, kind, cpu, word);
                if (kind == 1) m_en[cpu][word] = wdata;
            end
            m_s2 = m_s1;
            m_s1 = src;
            m_irq = nirq;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(m_rtag, rdata, m_rd);
            chk("R6", {30'd0, irq}, {30'd0, m_irq});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic bus_read(input int a, input logic [31:0] exp, input string tag);
        rd_en = 1'b1; addr = AW'(a);
        @(negedge clk);
        chk(tag, rdata, exp);
        #1 rd_en = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;
        // R1: reset state
        chk("R1", {30'd0, irq}, 32'd0);
        chk("R1", rdata, 32'd0);
        bus_read(0, 32'd0, "R1");
        bus_read(4, 32'd0, "R1");
        bus_read(16, 32'd0, "R1");
        bus_read(20, 32'd0, "R1");

        // R2: cpu0 first enable slot covers sources 32..63
        bus_write(0, 32'h0000_0001);
        src[32] = 1'b1;
        idle(3);
        chk("R2", {31'd0, irq[0]}, 32'd1);
        chk("R2", {31'd0, irq[1]}, 32'd0);
        src = '0; src[0] = 1'b1;
        idle(3);
        chk("R2", {31'd0, irq[0]}, 32'd0);

        // R3: full-word store, per-cpu independence
        bus_write(20, 32'hA5A5_0F0F);
        bus_read(20, 32'hA5A5_0F0F, "R3");
        bus_read(4, 32'd0, "R3");
        bus_read(0, 32'h0000_0001, "R3");

        // R6: cpu1 sees source 0, then mask timing
        chk("R6", {31'd0, irq[1]}, 32'd1);
        bus_write(20, 32'd0);
        chk("R6", {31'd0, irq[1]}, 32'd1);
        idle(1);
        chk("R6", {31'd0, irq[1]}, 32'd0);

        // R4: status read-back, identical in both banks
        src = {32'h8000_0001, 32'h0000_0010};
        idle(3);
        bus_read(8, 32'h8000_0001, "R4");
        bus_read(12, 32'h0000_0010, "R4");
        bus_read(24, 32'h8000_0001, "R4");
        bus_read(28, 32'h0000_0010, "R4");

        // R7: status writes ignored
        bus_write(8, 32'hFFFF_FFFF);
        bus_write(28, 32'hFFFF_FFFF);
        bus_read(0, 32'h0000_0001, "R7");
        bus_read(8, 32'h8000_0001, "R7");
        bus_read(20, 32'd0, "R7");

        // R8: unmapped window
        bus_write(32, 32'hFFFF_FFFF);
        bus_write(252, 32'hFFFF_FFFF);
        bus_read(32, 32'd0, "R8");
        bus_read(252, 32'd0, "R8");
        bus_read(16, 32'd0, "R8");
        bus_read(0, 32'h0000_0001, "R8");

        // R5: data only the cycle after a strobe
        idle(1);
        chk("R5", rdata, 32'd0);

        // R9: one-cycle pulse, no latching
        src = '0;
        bus_write(0, 32'hFFFF_FFFF);
        idle(3);
        chk("R9", {31'd0, irq[0]}, 32'd0);
        src[40] = 1'b1;
        idle(1);
        src[40] = 1'b0;
        idle(2);
        chk("R9", {31'd0, irq[0]}, 32'd1);
        idle(1);
        chk("R9", {31'd0, irq[0]}, 32'd0);

        idle(3);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule